// File: doc/BRIEF.md
# Burst Address Generator

This block is the per-port address source in front of a synchronous memory array. Each cycle it produces the address that the array uses for that cycle's read or write. The address comes from an external address bus or from an internal burst counter. Three active-low controls steer it: a strobe that loads the external address, a count enable that steps the counter, and a clear that forces the counter to zero.

The controls follow a fixed priority: clear first, then strobe, then count enable. A strobed or cleared address is used in the same cycle it is applied, so neither costs a dead cycle. The counter spans the whole address range and wraps from the top address back to zero. The block does not depend on any chip-enable signal. A dual-port memory uses one instance per port.

The address width is a parameter. The effective address is combinational and valid within the current cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `clr_n` is 0, `eff_addr` is 0 in that same cycle, whatever `strobe_n`, `cnt_en_n` and `ext_addr` are.
- R2: While `clr_n` is 1 and `strobe_n` is 0, `eff_addr` equals `ext_addr` in that same cycle, and the counter takes that value.
- R3: `cnt_en_n` has no effect in a cycle where `strobe_n` or `clr_n` is 0. A following hold cycle presents the cleared or strobed address, not that address plus one.
- R4: While `clr_n` and `strobe_n` are both 1 and `cnt_en_n` is 0, `eff_addr` is one more than the address presented in the previous cycle.
- R5: While `clr_n`, `strobe_n` and `cnt_en_n` are all 1, `eff_addr` repeats the previous cycle's address, and `ext_addr` is ignored.
- R6: Incrementing from the all-ones address (2^AW-1) gives address 0.
- R7: A clear costs no dead cycle. The clear cycle itself accesses address 0, and an increment in the very next cycle accesses address 1.
- R8: The synchronous active-high `rst` sets the counter to 0. The first hold cycle after reset presents address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the counter |
| ext_addr | input | AW | External address |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| cnt_en_n | input | 1 | Active-low counter increment |
| clr_n | input | 1 | Active-low counter clear to zero |
| eff_addr | output | AW | Address accessed in the current cycle |

## Verification
Clear, strobe and count enable can all be asserted in the same cycle, and only the highest-priority one may take effect. The bench drives every overlap of the three controls: clear with strobe, clear with count enable, strobe with count enable, and all three together. In each case it compares the same-cycle address and the address in the cycle that follows against a behavioural model. The model applies the priority order directly. Directed runs across the all-ones address and a clear followed at once by increments cover the wrap and the no-dead-cycle cases.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Operation resolved from the three controls for one cycle.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_LOAD = 2'd2,
        OP_CLR  = 2'd3
    } burst_op_e;

    // Control requests, already converted to active-high.
    typedef struct packed {
        logic clr;
        logic load;
        logic step;
    } burst_ctl_t;

    // Fixed priority: clear over load over step.
    function automatic burst_op_e resolve_op(input burst_ctl_t c);
        burst_op_e op;
        if (c.clr)
            op = OP_CLR;
        else if (c.load)
            op = OP_LOAD;
        else if (c.step)
            op = OP_INC;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  logic      strobe_n,
    input  logic      cnt_en_n,
    input  logic      clr_n,
    output burst_op_e op
);
    burst_ctl_t ctl;

    always_comb begin
        ctl.clr  = ~clr_n;
        ctl.load = ~strobe_n;
        ctl.step = ~cnt_en_n;
        op       = resolve_op(ctl);
    end

endmodule

// File: rtl/burst_addr_select.sv
module burst_addr_select
    import burst_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input  burst_op_e        op,
    input  logic [AW-1:0]    ext_addr,
    input  logic [AW-1:0]    cnt_q,
    output logic [AW-1:0]    eff_addr
);
    localparam logic [AW-1:0] ZERO_ADDR = '0;
    localparam logic [AW-1:0] ONE_ADDR  = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] stepped;

    // Modulo-2^AW add: the carry out is dropped, so the top address wraps to zero.
    always_comb stepped = cnt_q + ONE_ADDR;

    always_comb begin
        unique case (op)
            OP_CLR:  eff_addr = ZERO_ADDR;
            OP_LOAD: eff_addr = ext_addr;
            OP_INC:  eff_addr = stepped;
            default: eff_addr = cnt_q;
        endcase
    end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          strobe_n,
    input  logic          cnt_en_n,
    input  logic          clr_n,
    output logic [AW-1:0] eff_addr
);
    burst_op_e     op;
    logic [AW-1:0] cnt_q;

    burst_op_decode u_decode (
        .strobe_n (strobe_n),
        .cnt_en_n (cnt_en_n),
        .clr_n    (clr_n),
        .op       (op)
    );

    burst_addr_select #(.AW(AW)) u_select (
        .op       (op),
        .ext_addr (ext_addr),
        .cnt_q    (cnt_q),
        .eff_addr (eff_addr)
    );

    // The counter always follows the address used this cycle.
    burst_addr_reg #(.AW(AW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .d   (eff_addr),
        .q   (cnt_q)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ext_addr,
    input logic          strobe_n,
    input logic          cnt_en_n,
    input logic          clr_n,
    input logic [AW-1:0] eff_addr
);
    logic [AW-1:0] last_eff;
    logic          last_vld;

    // Remembers the previous cycle's address; valid from the second cycle after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_eff <= '0;
            last_vld <= 1'b0;
        end else begin
            last_eff <= eff_addr;
            last_vld <= 1'b1;
        end
    end

    wire do_inc  = clr_n && strobe_n && !cnt_en_n;
    wire do_hold = clr_n && strobe_n && cnt_en_n;

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (eff_addr == '0));

    a_r2_load_ext: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !strobe_n) |-> (eff_addr == ext_addr));

    a_r3_load_ignores_step: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !strobe_n && !cnt_en_n) |-> (eff_addr == ext_addr));

    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (last_vld && do_inc) |-> (eff_addr == last_eff + 1'b1));

    a_r5_hold_same: assert property (@(posedge clk) disable iff (rst)
        (last_vld && do_hold) |-> (eff_addr == last_eff));

    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (last_vld && do_inc && (&last_eff)) |-> (eff_addr == '0));

    a_r8_reset_zero: assert property (@(posedge clk)
        ($fell(rst) && do_hold) |-> (eff_addr == '0));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .cnt_en_n (cnt_en_n),
    .clr_n    (clr_n),
    .eff_addr (eff_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic          clr_n    = 1'b1;
    logic [AW-1:0] eff_addr;

    int n_vec  = 0;
    int n_fail = 0;
    int model_cnt = 0;
    int lfsr = 32'h1ACE;

    always #10 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .cnt_en_n(cnt_en_n), .clr_n(clr_n), .eff_addr(eff_addr)
    );

    // One cycle: drive after the falling edge, compare, then advance the model.
    task automatic step(input bit s_n, input bit c_n, input bit r_n, input int ext, input string tag);
        int exp_a;
        @(negedge clk);
        strobe_n = s_n; cnt_en_n = c_n; clr_n = r_n; ext_addr = ext[AW-1:0];
        #2;
        if (!r_n)      exp_a = 0;
        else if (!s_n) exp_a = ext % DEPTH;
        else if (!c_n) exp_a = (model_cnt + 1) % DEPTH;
        else           exp_a = model_cnt;
        n_vec++;
        if (int'(eff_addr) != exp_a) begin
            n_fail++;
            $display("FAIL %s: eff_addr=%0d expected=%0d", tag, eff_addr, exp_a);
        end
        model_cnt = exp_a;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_cnt = 0;
        step(1, 1, 1, 8'hA5, "R8 hold after reset");
        step(1, 0, 1, 8'h33, "R4 step from reset");
        step(0, 1, 1, 8'h40, "R2 load");
        step(1, 0, 1, 8'h11, "R4 step after load");
        step(1, 0, 1, 8'h22, "R4 step");
        step(1, 1, 1, 8'h99, "R5 hold ignores ext");
        step(0, 0, 1, 8'h70, "R3 load with step");
        step(1, 1, 1, 8'h00, "R3 hold after load+step");
        step(0, 0, 0, 8'h55, "R1 clear over all");
        step(1, 1, 1, 8'h55, "R3 hold after clear");
        step(0, 1, 0, 8'h66, "R1 clear over load");
        step(1, 0, 1, 8'h66, "R7 step after clear");
        step(1, 1, 0, 8'h01, "R1 clear alone");
        step(1, 0, 0, 8'h01, "R1 clear with step");
        step(1, 0, 1, 8'h01, "R7 step to one");
        step(0, 1, 1, DEPTH - 2, "R2 load near top");
        step(1, 0, 1, 0, "R4 step to top");
        step(1, 0, 1, 0, "R6 wrap to zero");
        step(1, 0, 1, 0, "R6 step after wrap");
        step(0, 0, 1, DEPTH - 1, "R3 load top with step");
        step(1, 0, 1, 0, "R6 wrap after load");
        for (int i = 0; i < 2000; i++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
            step(lfsr[20], lfsr[21] & lfsr[22], lfsr[23] | lfsr[24] | lfsr[25],
                 (lfsr >> 4) & (DEPTH - 1), "R1 R2 R3 R4 R5 mixed");
        end
        for (int i = 0; i < DEPTH + 3; i++)
            step(1, 0, 1, i, "R6 full sweep");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule